// File: doc/BRIEF.md
# NAND Flash Command and Address Sequencer

This block sits on the host side of an 8-bit multiplexed NAND flash bus. A host hands it one request over a valid/ready handshake. The request carries an operation kind (read, program or erase), a first command byte, an optional second command byte, a block number, a page number, a column offset and a byte count. The sequencer then drives chip enable, command latch, address latch, write strobe, read strobe and write protect. It drives the shared data byte or samples it. Program data comes in on a valid/ready input stream, one byte for each write strobe. Read data, sampled as the read strobe rises, leaves on a valid/ready output stream.

The controller is a single state machine. The states are IDLE, SETUP, WE_LO, WE_HI, WGET, BUSY, GAP, RE_LO, RE_HI and FIN. A phase register (CMD1, ADDR, WDATA, CMD2) records which kind of byte a strobe carries. The transitions are as follows:
- IDLE→SETUP when a request is accepted.
- SETUP→WE_LO→WE_HI as each strobe timer expires.
- WE_HI→SETUP for the next command or address byte.
- WE_HI→WGET to fetch a program byte.
- WE_HI→BUSY after the last byte.
- WGET→SETUP once a write byte arrives.
- BUSY→GAP when ready/busy reads high.
- BUSY→IDLE on timeout.
- GAP→RE_LO for read data, or GAP→FIN when there is none.
- RE_LO→RE_HI at each sample.
- RE_HI→RE_LO for the next byte, or RE_HI→FIN after the last.
- FIN→IDLE.

Each strobe width comes from a run-time clock-count input. An address is always four strobes: the column comes first, then the row, and each is sent low byte first. The row is formed as block × 64 + page.

Top module: `nand_cmd_seq`

## Requirements
- R1: After reset, and whenever idle, CE#, WE# and RE# are high, CLE and ALE are low, WP# is low and req_ready is high.
- R2: Each command byte is on the data lines with CLE high and ALE low while WE# rises. CLE is never high together with ALE.
- R3: After the first command come exactly four address strobes with ALE high and CLE low. Their values, in order, are: column[7:0]; {4'b0000, column[11:8]}; row[7:0]; row[15:8]. Here row = block × 64 + page.
- R4: Phases run in this order: first command, four address bytes, program data (program only, req_op = 1), second command (only if req_has_cmd2 = 1), then the ready/busy wait. Read is req_op = 0 and erase is req_op = 2.
- R5: WE# stays low for cfg_we_lo clocks and RE# stays low for cfg_re_lo clocks. A programmed value of 0 acts as 1.
- R6: A program or erase request made while host_wp = 1 raises err_wp for one clock and produces no bus activity (CE# stays high). A read is still accepted. During program and erase WP# is high; during a read it is low.
- R7: A request with column + length > 2112 raises err_range for one clock and produces no bus activity. Column + length = 2112 is accepted.
- R8: No RE# pulse and no done occur while ready/busy is low. The first RE# falls cfg_rb_wait clocks after the clock edge at which ready/busy is first seen high.
- R9: If ready/busy stays low for more than cfg_timeout clocks in BUSY, err_timeout pulses, done does not, and the block returns to idle.
- R10: A read delivers exactly req_len bytes, in the order the flash presents them. While rd_ready is low, rd_data is held and no further RE# pulse starts.
- R11: A program sends exactly req_len bytes from the write stream, one per WE# pulse. CE# stays low from the first command to the end of the operation.
- R12: done pulses for one clock when an operation completes normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Sequencer idle and able to take a request |
| req_op | input | 2 | 0 read, 1 program, 2 erase |
| req_cmd1 | input | 8 | First command byte |
| req_has_cmd2 | input | 1 | Send a second command byte |
| req_cmd2 | input | 8 | Second command byte |
| req_block | input | 10 | Block number |
| req_page | input | 6 | Page within the block |
| req_col | input | 12 | Column offset within the 2112-byte page |
| req_len | input | 12 | Data byte count |
| host_wp | input | 1 | Host write protect |
| cfg_setup | input | 8 | Clocks of latch setup before WE# falls |
| cfg_we_lo | input | 8 | WE# low clocks |
| cfg_we_hi | input | 8 | WE# high clocks after each strobe |
| cfg_re_lo | input | 8 | RE# low clocks |
| cfg_re_hi | input | 8 | RE# high clocks between reads |
| cfg_rb_wait | input | 8 | Clocks from ready to first RE# |
| cfg_timeout | input | 16 | Ready/busy timeout in clocks |
| wr_valid | input | 1 | Program byte offered |
| wr_ready | output | 1 | Program byte taken |
| wr_data | input | 8 | Program byte |
| rd_valid | output | 1 | Read byte available |
| rd_ready | input | 1 | Read byte consumed |
| rd_data | output | 8 | Read byte |
| done | output | 1 | Operation finished |
| err_range | output | 1 | Request exceeded the page |
| err_wp | output | 1 | Program/erase refused by write protect |
| err_timeout | output | 1 | Ready/busy timeout |
| nand_ce_n | output | 1 | Chip enable, active low |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_wp_n | output | 1 | Write protect, active low |
| nand_dq_out | output | 8 | Byte driven onto the bus |
| nand_dq_oe | output | 1 | Bus drive enable |
| nand_dq_in | input | 8 | Byte sampled from the bus |
| nand_rb_n | input | 1 | Ready/busy, low while busy |

## Verification
Each bus and stream output is decoded from the registered state, so it appears in the cycle after the edge that changes state. The bench therefore watches the bus on the falling clock edge and counts its own clocks. Its timing rules follow from that:
- A strobe's low width is expected to be exactly the programmed count.
- A byte is logged at the first falling edge after WE# is seen high.
- The first RE# low is expected exactly cfg_rb_wait falling edges after ready/busy is first seen high.

Error flags and done are one-clock pulses counted at falling edges. Each test compares these counts against a snapshot taken before its request, together with the CE# activity count, so that "no bus activity" is shown at the pins.

// File: rtl/nand_seq_pkg.sv
package nand_seq_pkg;
    typedef enum logic [1:0] {
        OP_READ  = 2'd0,
        OP_PROG  = 2'd1,
        OP_ERASE = 2'd2
    } nand_op_e;

    typedef enum logic [3:0] {
        ST_IDLE, ST_SETUP, ST_WE_LO, ST_WE_HI, ST_WGET,
        ST_BUSY, ST_GAP, ST_RE_LO, ST_RE_HI, ST_FIN
    } seq_state_e;

    typedef enum logic [1:0] {
        PH_CMD1, PH_ADDR, PH_WDATA, PH_CMD2
    } seq_phase_e;
endpackage

// File: rtl/nand_strobe_timer.sv
module nand_strobe_timer #(
    parameter int TW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [TW-1:0] load_val,
    output logic          expired
);
    logic [TW-1:0] cnt;

    // A zero count is raised to one so every phase lasts at least a clock.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= TW'(1);
        else if (load)
            cnt <= (load_val == '0) ? TW'(1) : load_val;
        else if (cnt > TW'(1))
            cnt <= cnt - TW'(1);
    end

    assign expired = (cnt == TW'(1));
endmodule

// File: rtl/nand_addr_pack.sv
module nand_addr_pack #(
    parameter int COL_W = 12,
    parameter int BLK_W = 10,
    parameter int PG_W  = 6
) (
    input  logic [COL_W-1:0] col,
    input  logic [BLK_W-1:0] blk,
    input  logic [PG_W-1:0]  pg,
    input  logic [1:0]       idx,
    output logic [7:0]       abyte
);
    logic [11:0] col12;
    logic [15:0] row16;

    assign col12 = 12'(col);
    // Concatenating block above page is block * 2**PG_W + page.
    assign row16 = 16'({blk, pg});

    always_comb begin
        unique case (idx)
            2'd0:    abyte = col12[7:0];
            2'd1:    abyte = {4'b0000, col12[11:8]};
            2'd2:    abyte = row16[7:0];
            default: abyte = row16[15:8];
        endcase
    end
endmodule

// File: rtl/nand_cmd_seq.sv
module nand_cmd_seq
    import nand_seq_pkg::*;
#(
    parameter int COL_W      = 12,
    parameter int BLK_W      = 10,
    parameter int PG_W       = 6,
    parameter int TW         = 8,
    parameter int TOW        = 16,
    parameter int PAGE_BYTES = 2112
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [1:0]       req_op,
    input  logic [7:0]       req_cmd1,
    input  logic             req_has_cmd2,
    input  logic [7:0]       req_cmd2,
    input  logic [BLK_W-1:0] req_block,
    input  logic [PG_W-1:0]  req_page,
    input  logic [COL_W-1:0] req_col,
    input  logic [COL_W-1:0] req_len,
    input  logic             host_wp,
    input  logic [TW-1:0]    cfg_setup,
    input  logic [TW-1:0]    cfg_we_lo,
    input  logic [TW-1:0]    cfg_we_hi,
    input  logic [TW-1:0]    cfg_re_lo,
    input  logic [TW-1:0]    cfg_re_hi,
    input  logic [TW-1:0]    cfg_rb_wait,
    input  logic [TOW-1:0]   cfg_timeout,
    input  logic             wr_valid,
    output logic             wr_ready,
    input  logic [7:0]       wr_data,
    output logic             rd_valid,
    input  logic             rd_ready,
    output logic [7:0]       rd_data,
    output logic             done,
    output logic             err_range,
    output logic             err_wp,
    output logic             err_timeout,
    output logic             nand_ce_n,
    output logic             nand_cle,
    output logic             nand_ale,
    output logic             nand_we_n,
    output logic             nand_re_n,
    output logic             nand_wp_n,
    output logic [7:0]       nand_dq_out,
    output logic             nand_dq_oe,
    input  logic [7:0]       nand_dq_in,
    input  logic             nand_rb_n
);
    localparam int SPAN_W = COL_W + 1;

    seq_state_e       state, state_n;
    seq_phase_e       ph_q, ph_n;
    nand_op_e         op_q;
    logic             has2_q;
    logic [7:0]       cmd1_q, cmd2_q, wbyte_q, abyte;
    logic [BLK_W-1:0] blk_q;
    logic [PG_W-1:0]  pg_q;
    logic [COL_W-1:0] col_q, rem_q;
    logic [1:0]       idx_q;
    logic [TOW-1:0]   tcnt_q;
    logic [TW-1:0]    tval;
    logic             tmr_exp, tmr_load;
    logic [SPAN_W-1:0] span;
    logic             span_bad, wp_block, accept, go_wdata, bus_phase;

    // Request screening: page overrun first, then write protect.
    assign span     = {1'b0, req_col} + {1'b0, req_len};
    assign span_bad = span > SPAN_W'(PAGE_BYTES);
    assign wp_block = host_wp && (req_op != 2'(OP_READ));
    assign accept   = req_valid && !span_bad && !wp_block;
    assign go_wdata = (op_q == OP_PROG) && (rem_q != '0);

    nand_addr_pack #(.COL_W(COL_W), .BLK_W(BLK_W), .PG_W(PG_W)) u_pack (
        .col(col_q), .blk(blk_q), .pg(pg_q), .idx(idx_q), .abyte(abyte)
    );

    always_comb begin
        unique case (state_n)
            ST_SETUP: tval = cfg_setup;
            ST_WE_LO: tval = cfg_we_lo;
            ST_WE_HI: tval = cfg_we_hi;
            ST_GAP:   tval = cfg_rb_wait;
            ST_RE_LO: tval = cfg_re_lo;
            ST_RE_HI: tval = cfg_re_hi;
            default:  tval = TW'(1);
        endcase
    end
    assign tmr_load = (state_n != state);

    nand_strobe_timer #(.TW(TW)) u_tmr (
        .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tval), .expired(tmr_exp)
    );

    // Next-state logic.
    always_comb begin
        state_n = state;
        ph_n    = ph_q;
        unique case (state)
            ST_IDLE:  if (accept) begin state_n = ST_SETUP; ph_n = PH_CMD1; end
            ST_SETUP: if (tmr_exp) state_n = ST_WE_LO;
            ST_WE_LO: if (tmr_exp) state_n = ST_WE_HI;
            ST_WE_HI: if (tmr_exp) begin
                unique case (ph_q)
                    PH_CMD1: begin state_n = ST_SETUP; ph_n = PH_ADDR; end
                    PH_ADDR: begin
                        if (idx_q != 2'd3)  state_n = ST_SETUP;
                        else if (go_wdata)  begin state_n = ST_WGET; ph_n = PH_WDATA; end
                        else if (has2_q)    begin state_n = ST_SETUP; ph_n = PH_CMD2; end
                        else                state_n = ST_BUSY;
                    end
                    PH_WDATA: begin
                        if (rem_q != '0)    state_n = ST_WGET;
                        else if (has2_q)    begin state_n = ST_SETUP; ph_n = PH_CMD2; end
                        else                state_n = ST_BUSY;
                    end
                    default: state_n = ST_BUSY;
                endcase
            end
            ST_WGET:  if (wr_valid) state_n = ST_SETUP;
            ST_BUSY: begin
                if (nand_rb_n)                  state_n = ST_GAP;
                else if (tcnt_q >= cfg_timeout) state_n = ST_IDLE;
            end
            ST_GAP:   if (tmr_exp) state_n = (op_q == OP_READ && rem_q != '0) ? ST_RE_LO : ST_FIN;
            ST_RE_LO: if (tmr_exp) state_n = ST_RE_HI;
            ST_RE_HI: if (tmr_exp && !rd_valid) state_n = (rem_q != '0) ? ST_RE_LO : ST_FIN;
            ST_FIN:   state_n = ST_IDLE;
            default:  state_n = ST_IDLE;
        endcase
    end

    // State register and datapath.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;   ph_q <= PH_CMD1;  op_q <= OP_READ;
            has2_q <= 1'b0;     cmd1_q <= '0;     cmd2_q <= '0;
            blk_q <= '0;        pg_q <= '0;       col_q <= '0;
            rem_q <= '0;        idx_q <= '0;      wbyte_q <= '0;
            tcnt_q <= '0;       rd_valid <= 1'b0; rd_data <= '0;
            err_range <= 1'b0;  err_wp <= 1'b0;   err_timeout <= 1'b0;
        end else begin
            state <= state_n;
            ph_q  <= ph_n;
            err_range   <= (state == ST_IDLE) && req_valid && span_bad;
            err_wp      <= (state == ST_IDLE) && req_valid && !span_bad && wp_block;
            err_timeout <= (state == ST_BUSY) && !nand_rb_n && (tcnt_q >= cfg_timeout);
            tcnt_q <= (state == ST_BUSY) ? tcnt_q + TOW'(1) : '0;
            if (state == ST_IDLE && accept) begin
                op_q <= nand_op_e'(req_op);  has2_q <= req_has_cmd2;
                cmd1_q <= req_cmd1;          cmd2_q <= req_cmd2;
                blk_q <= req_block;          pg_q <= req_page;
                col_q <= req_col;            rem_q <= req_len;
                idx_q <= '0;
            end
            if (state == ST_WE_HI && tmr_exp && ph_q == PH_ADDR)
                idx_q <= idx_q + 2'd1;
            if (state == ST_WGET && wr_valid) begin
                wbyte_q <= wr_data;
                rem_q   <= rem_q - COL_W'(1);
            end
            if (state == ST_RE_LO && tmr_exp) begin
                rd_data  <= nand_dq_in;
                rd_valid <= 1'b1;
                rem_q    <= rem_q - COL_W'(1);
            end else if (rd_valid && rd_ready) begin
                rd_valid <= 1'b0;
            end
        end
    end

    // Outputs decoded from the registered state.
    always_comb begin
        bus_phase   = (state == ST_SETUP) || (state == ST_WE_LO) || (state == ST_WE_HI);
        req_ready   = (state == ST_IDLE);
        wr_ready    = (state == ST_WGET);
        done        = (state == ST_FIN);
        nand_ce_n   = (state == ST_IDLE);
        nand_we_n   = (state != ST_WE_LO);
        nand_re_n   = (state != ST_RE_LO);
        nand_cle    = bus_phase && (ph_q == PH_CMD1 || ph_q == PH_CMD2);
        nand_ale    = bus_phase && (ph_q == PH_ADDR);
        nand_dq_oe  = bus_phase;
        nand_wp_n   = (state != ST_IDLE) && (op_q != OP_READ);
        unique case (ph_q)
            PH_CMD1:  nand_dq_out = cmd1_q;
            PH_ADDR:  nand_dq_out = abyte;
            PH_WDATA: nand_dq_out = wbyte_q;
            default:  nand_dq_out = cmd2_q;
        endcase
    end

    // R2: command and address latches never overlap.
    p_latch_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(nand_cle && nand_ale));
    // R11: a write strobe only happens with the chip selected.
    p_ce_on_strobe_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !nand_we_n |-> !nand_ce_n);
    // R6: program/erase strobes always see write protect released.
    p_wp_released_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!nand_we_n && op_q != OP_READ) |-> nand_wp_n);
    // R8: no read strobe while the flash reports busy.
    p_no_re_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !nand_re_n |-> nand_rb_n);
    // R7: a rejected request leaves the chip deselected.
    p_reject_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (err_range || err_wp) |-> nand_ce_n);
    // R10: a stalled read byte stays put.
    p_rd_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data)));
    // R2: the bus is never driven during a read strobe.
    p_no_drive_on_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
        nand_dq_oe |-> nand_re_n);
endmodule

// File: tb/sim_nand_cmd_seq.sv
module sim_nand_cmd_seq;
    typedef struct packed {
        logic [1:0]  op;
        logic        has2;
        logic [7:0]  c1;
        logic [7:0]  c2;
        logic [9:0]  blk;
        logic [5:0]  pg;
        logic [11:0] col;
        logic [11:0] len;
        logic [15:0] erow;   // expected row = block*64 + page
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VT [0:NV-1] = '{
        '{2'd0, 1'b1, 8'h00, 8'h30, 10'd5,    6'd3,  12'd0,    12'd4, 16'h0143},
        '{2'd0, 1'b1, 8'h00, 8'h30, 10'd1023, 6'd63, 12'd2050, 12'd3, 16'hFFFF},
        '{2'd1, 1'b1, 8'h80, 8'h10, 10'd2,    6'd1,  12'd16,   12'd3, 16'h0081},
        '{2'd2, 1'b1, 8'h60, 8'hD0, 10'd7,    6'd0,  12'd0,    12'd0, 16'h01C0},
        '{2'd0, 1'b1, 8'h00, 8'h30, 10'd0,    6'd0,  12'd2108, 12'd4, 16'h0000},
        '{2'd0, 1'b0, 8'h70, 8'h00, 10'd9,    6'd10, 12'd100,  12'd2, 16'h024A}
    };

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic rst_n = 1'b0;
    logic req_valid = 1'b0, req_has_cmd2 = 1'b0, host_wp = 1'b0;
    logic [1:0] req_op = '0;
    logic [7:0] req_cmd1 = '0, req_cmd2 = '0;
    logic [9:0] req_block = '0;
    logic [5:0] req_page = '0;
    logic [11:0] req_col = '0, req_len = '0;
    logic [7:0] cfg_setup = 8'd1, cfg_we_lo = 8'd2, cfg_we_hi = 8'd2;
    logic [7:0] cfg_re_lo = 8'd2, cfg_re_hi = 8'd1, cfg_rb_wait = 8'd3;
    logic [15:0] cfg_timeout = 16'd200;
    logic wr_valid = 1'b1, rd_ready = 1'b1;
    logic req_ready, wr_ready, rd_valid, done, err_range, err_wp, err_timeout;
    logic [7:0] rd_data, wr_data, nand_dq_out, nand_dq_in;
    logic nand_ce_n, nand_cle, nand_ale, nand_we_n, nand_re_n, nand_wp_n, nand_dq_oe, nand_rb_n;

    int busy_len = 20;
    int busy_left = 0;
    int wr_idx = 0, rd_idx = 0, rd_n = 0, log_n = 0, tcyc = 0;
    int done_n = 0, rng_n = 0, wp_n_cnt = 0, to_n = 0, ce_low_n = 0, re_rise_n = 0;
    int lo_run = 0, last_we_lo = 0, re_run = 0, last_re_lo = 0;
    int rb_rise_t = 0, last_gap = -1;
    bit gap_armed = 1'b0;
    logic prev_we = 1'b1, prev_re = 1'b1, prev_rb = 1'b1;
    logic [7:0] log_b [0:255];
    logic       log_c [0:255];
    logic       log_a [0:255];
    logic       log_w [0:255];
    logic [7:0] rd_log [0:255];
    int checks = 0, failures = 0;

    assign nand_rb_n  = (busy_left == 0);
    assign wr_data    = wr_idx[7:0] ^ 8'hC3;
    assign nand_dq_in = rd_idx[7:0] * 8'd7 + 8'd1;

    nand_cmd_seq u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_op(req_op), .req_cmd1(req_cmd1), .req_has_cmd2(req_has_cmd2), .req_cmd2(req_cmd2),
        .req_block(req_block), .req_page(req_page), .req_col(req_col), .req_len(req_len),
        .host_wp(host_wp), .cfg_setup(cfg_setup), .cfg_we_lo(cfg_we_lo), .cfg_we_hi(cfg_we_hi),
        .cfg_re_lo(cfg_re_lo), .cfg_re_hi(cfg_re_hi), .cfg_rb_wait(cfg_rb_wait),
        .cfg_timeout(cfg_timeout), .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
        .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data), .done(done),
        .err_range(err_range), .err_wp(err_wp), .err_timeout(err_timeout),
        .nand_ce_n(nand_ce_n), .nand_cle(nand_cle), .nand_ale(nand_ale), .nand_we_n(nand_we_n),
        .nand_re_n(nand_re_n), .nand_wp_n(nand_wp_n), .nand_dq_out(nand_dq_out),
        .nand_dq_oe(nand_dq_oe), .nand_dq_in(nand_dq_in), .nand_rb_n(nand_rb_n)
    );

    // Stream handshakes complete at the rising edge.
    always @(posedge clk) begin
        if (wr_valid && wr_ready) wr_idx <= wr_idx + 1;
        if (rd_valid && rd_ready) begin
            rd_log[rd_n[7:0]] <= rd_data;
            rd_n <= rd_n + 1;
        end
    end

    // Flash responder and bus monitor, sampled at the falling edge.
    always @(negedge clk) begin
        tcyc <= tcyc + 1;
        if (busy_left != 0) busy_left <= busy_left - 1;
        if (!prev_we && nand_we_n) begin
            log_b[log_n[7:0]] <= nand_dq_out;
            log_c[log_n[7:0]] <= nand_cle;
            log_a[log_n[7:0]] <= nand_ale;
            log_w[log_n[7:0]] <= nand_wp_n;
            log_n <= log_n + 1;
            if (nand_cle && (nand_dq_out == 8'h30 || nand_dq_out == 8'h10 || nand_dq_out == 8'hD0))
                busy_left <= busy_len;
        end
        if (!nand_we_n) lo_run <= lo_run + 1;
        else if (lo_run != 0) begin last_we_lo <= lo_run; lo_run <= 0; end
        if (!nand_re_n) re_run <= re_run + 1;
        else if (re_run != 0) begin last_re_lo <= re_run; re_run <= 0; end
        if (!prev_rb && nand_rb_n) begin rb_rise_t <= tcyc; gap_armed <= 1'b1; end
        if (prev_re && !nand_re_n && gap_armed) begin last_gap <= tcyc - rb_rise_t; gap_armed <= 1'b0; end
        if (!prev_re && nand_re_n) begin rd_idx <= rd_idx + 1; re_rise_n <= re_rise_n + 1; end
        if (!nand_ce_n) ce_low_n <= ce_low_n + 1;
        if (done) done_n <= done_n + 1;
        if (err_range) rng_n <= rng_n + 1;
        if (err_wp) wp_n_cnt <= wp_n_cnt + 1;
        if (err_timeout) to_n <= to_n + 1;
        prev_we <= nand_we_n;
        prev_re <= nand_re_n;
        prev_rb <= nand_rb_n;
    end

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic issue(input vec_t v);
        @(negedge clk);
        req_op = v.op; req_has_cmd2 = v.has2; req_cmd1 = v.c1; req_cmd2 = v.c2;
        req_block = v.blk; req_page = v.pg; req_col = v.col; req_len = v.len;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic wait_end(input int maxc);
        int d0 = done_n, e0 = rng_n + wp_n_cnt + to_n;
        for (int i = 0; i < maxc; i++) begin
            @(negedge clk);
            if (done_n != d0 || rng_n + wp_n_cnt + to_n != e0) break;
        end
        repeat (2) @(negedge clk);
    endtask

    task automatic run_vec(input vec_t v, input string tag);
        logic [7:0] eb [0:31];
        bit ec [0:31];
        bit ea [0:31];
        int n = 0, ls = log_n, ws = wr_idx, rs = rd_idx, rn = rd_n, d0 = done_n, bad = -1;
        eb[0] = v.c1; ec[0] = 1; ea[0] = 0; n = 1;
        eb[1] = v.col[7:0];        eb[2] = {4'b0000, v.col[11:8]};
        eb[3] = v.erow[7:0];       eb[4] = v.erow[15:8];
        for (int k = 1; k < 5; k++) begin ec[k] = 0; ea[k] = 1; end
        n = 5;
        if (v.op == 2'd1)
            for (int k = 0; k < int'(v.len); k++) begin
                eb[n] = 8'((ws + k) ^ 8'hC3); ec[n] = 0; ea[n] = 0; n++;
            end
        if (v.has2) begin eb[n] = v.c2; ec[n] = 1; ea[n] = 0; n++; end
        issue(v);
        wait_end(2000);
        chk(done_n == d0 + 1, "R12", {tag, " done pulse"}, done_n - d0, 1);
        chk(log_n - ls == n, "R4", {tag, " strobe count"}, log_n - ls, n);
        for (int k = 0; k < n && k < log_n - ls; k++)
            if (bad < 0 && (log_b[(ls + k) % 256] != eb[k] || log_c[(ls + k) % 256] != ec[k] ||
                            log_a[(ls + k) % 256] != ea[k])) bad = k;
        chk(bad < 0, "R3", {tag, " command/address/data bytes, first bad index"}, bad, -1);
        bad = -1;
        for (int k = 0; k < log_n - ls; k++)
            if (bad < 0 && log_w[(ls + k) % 256] != (v.op != 2'd0)) bad = k;
        chk(bad < 0, "R6", {tag, " WP# level per strobe, first bad index"}, bad, -1);
        if (v.op == 2'd0) begin
            chk(rd_n - rn == int'(v.len), "R10", {tag, " read byte count"}, rd_n - rn, int'(v.len));
            bad = -1;
            for (int k = 0; k < int'(v.len) && k < rd_n - rn; k++)
                if (bad < 0 && rd_log[(rn + k) % 256] != 8'((rs + k) * 7 + 1)) bad = k;
            chk(bad < 0, "R10", {tag, " read data order, first bad index"}, bad, -1);
        end
        if (v.op == 2'd1)
            chk(wr_idx - ws == int'(v.len), "R11", {tag, " write bytes taken"}, wr_idx - ws, int'(v.len));
    endtask

    initial begin
        #2_000_000;
        failures++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", tcyc, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        vec_t v;
        int c0, e0, d0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: idle pin levels after reset
        chk(nand_ce_n && nand_we_n && nand_re_n && !nand_cle && !nand_ale && !nand_wp_n && req_ready && !rd_valid,
            "R1", "idle levels", {nand_ce_n, nand_we_n, nand_re_n, nand_cle, nand_ale, nand_wp_n, req_ready},
            7'b1110001);

        for (int i = 0; i < NV; i++) run_vec(VT[i], $sformatf("vec%0d", i));
        chk(last_we_lo == 2, "R5", "WE# low width with count 2", last_we_lo, 2);
        chk(nand_ce_n && req_ready, "R1", "idle after operations", nand_ce_n, 1);

        // R8: gap from ready to first RE#
        cfg_rb_wait = 8'd5;
        run_vec(VT[0], "gap");
        chk(last_gap == 5, "R8", "ready to first RE# clocks", last_gap, 5);

        // R5: strobe widths and zero treated as one
        cfg_we_lo = 8'd3; cfg_re_lo = 8'd3;
        run_vec(VT[0], "wide");
        chk(last_we_lo == 3, "R5", "WE# low width 3", last_we_lo, 3);
        chk(last_re_lo == 3, "R5", "RE# low width 3", last_re_lo, 3);
        cfg_we_lo = 8'd0; cfg_re_lo = 8'd0; cfg_setup = 8'd0; cfg_we_hi = 8'd0;
        run_vec(VT[2], "zero");
        chk(last_we_lo == 1, "R5", "WE# low width for count 0", last_we_lo, 1);
        cfg_we_lo = 8'd2; cfg_re_lo = 8'd2; cfg_setup = 8'd1; cfg_we_hi = 8'd2;

        // R7: page overrun rejected without bus activity
        v = VT[4]; v.col = 12'd2109;
        c0 = ce_low_n; e0 = rng_n;
        issue(v); repeat (6) @(negedge clk);
        chk(rng_n == e0 + 1, "R7", "err_range pulses", rng_n - e0, 1);
        chk(ce_low_n == c0, "R7", "CE# low clocks on overrun", ce_low_n - c0, 0);

        // R6: write protect blocks erase, allows read
        host_wp = 1'b1;
        c0 = ce_low_n; e0 = wp_n_cnt;
        issue(VT[3]); repeat (6) @(negedge clk);
        chk(wp_n_cnt == e0 + 1, "R6", "err_wp pulses", wp_n_cnt - e0, 1);
        chk(ce_low_n == c0, "R6", "CE# low clocks on protected erase", ce_low_n - c0, 0);
        run_vec(VT[5], "wp_read");
        host_wp = 1'b0;

        // R10: read backpressure
        rd_ready = 1'b0;
        c0 = re_rise_n; d0 = rd_n;
        issue(VT[1]);
        repeat (120) @(negedge clk);
        chk(re_rise_n - c0 == 1, "R10", "RE# pulses while output full", re_rise_n - c0, 1);
        chk(rd_valid && rd_data == 8'((rd_idx - 1) * 7 + 1), "R10", "held byte", rd_data, 8'((rd_idx - 1) * 7 + 1));
        rd_ready = 1'b1;
        wait_end(2000);
        chk(rd_n - d0 == 3, "R10", "bytes after release", rd_n - d0, 3);

        // R9: busy timeout
        busy_len = 1000; cfg_timeout = 16'd50;
        d0 = done_n; e0 = to_n;
        issue(VT[0]);
        wait_end(500);
        chk(to_n == e0 + 1, "R9", "err_timeout pulses", to_n - e0, 1);
        chk(done_n == d0, "R9", "done after timeout", done_n - d0, 0);
        chk(nand_ce_n && req_ready, "R9", "idle after timeout", nand_ce_n, 1);
        for (int i = 0; i < 1200 && !nand_rb_n; i++) @(negedge clk);
        busy_len = 20; cfg_timeout = 16'd200;
        run_vec(VT[0], "after_timeout");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule